// File: doc/BRIEF.md
# Dual-Chamber Pacing Interval Sequencer

This block is the timing core of a two-chamber pacing controller. It steps through one heart cycle as a chain of timed windows. The chain is: refractory after a ventricular beat, atrial escape, blanking, crosstalk watch, atrioventricular delay, and a short safety-pacing path. A single down-counter, advanced by a 1 ms tick, times whichever window is active. The counter is reloaded with that window's programmed length each time the state changes.

Sensed atrial or ventricular events either end a window early or send the cycle down the safety path. A pace pulse is issued only when an escape or delay window runs out with no intrinsic beat seen. The six window lengths sit in registers written through a small write port. Each value is limited to its legal range as it is stored, which keeps the whole cycle inside safe bounds. A lockstep duplicate of this block can later be wrapped around it to compare outputs.

Top module: `pace_seq_top`

## Requirements
- R1: After reset `state_o` is 0 (idle) and both pace outputs are low. In idle an atrial sense has no effect, and a ventricular sense moves the block to the refractory state without any pace.
- R2: `state_o` encodes 0 idle, 1 post-ventricular refractory, 2 atrial escape, 3 blanking, 4 crosstalk window, 5 AV delay, 6 safety path. No other code ever appears.
- R3: On entering a timed state the timer is loaded with that state's length L. The state is left on the L-th tick after entry, or one clock after entry when L is 0. While `tick_i` is low the timer holds its value.
- R4: With no sensed events the order is refractory, escape, blanking, crosstalk window, AV delay, then back to refractory. The safety path is never visited.
- R5: `a_pace_o` is a one-cycle pulse in the first cycle of blanking, and only when the escape window expired. `v_pace_o` is a one-cycle pulse in the first cycle of refractory, and only when the AV delay or the safety path expired. The two are never high together.
- R6: In the escape window a ventricular sense returns to refractory and an atrial sense moves to blanking, both without a pace. When both senses arrive together, the ventricular one wins.
- R7: In the crosstalk window a ventricular sense moves to the safety path. An atrial sense there has no effect.
- R8: The safety path lasts its programmed length and ignores all senses. On expiry it issues a ventricular pace and returns to refractory.
- R9: In the AV delay a ventricular sense returns to refractory with no pace. An atrial sense there has no effect.
- R10: Senses during refractory or blanking change neither the state nor the time the state lasts.
- R11: A sense that the current state acts on, arriving in the same cycle the window expires, takes priority over the expiry, so no pace is issued.
- R12: A write selects a register with `wr_sel_i`: 0 refractory, 1 escape, 2 blanking, 3 crosstalk, 4 AV delay, 5 safety. The stored value is clamped to the limits refractory 300..400, escape 0..400, blanking 25, crosstalk 75, AV delay 100, safety 50..110. Values after reset are 350, 300, 25, 75, 100 and 100. A new value takes effect at the next entry to its state.
- R13: A cycle with no senses lasts 1000 ticks when refractory and escape are set to their upper limits. With lower limits it lasts 501 clocks when a tick arrives every clock, because the zero-length escape costs one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms time base enable, one clock wide |
| a_sense_i | input | 1 | Sensed atrial event pulse |
| v_sense_i | input | 1 | Sensed ventricular event pulse |
| wr_en_i | input | 1 | Interval register write strobe |
| wr_sel_i | input | 3 | Interval register select |
| wr_data_i | input | 10 | Interval length in ticks to write |
| a_pace_o | output | 1 | Atrial pace request pulse |
| v_pace_o | output | 1 | Ventricular pace request pulse |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with its default limits and reset lengths, and holds the tick high on every clock. As a result a window of L ticks lasts exactly L clocks, and a complete 1000 ms cycle fits in about a thousand clocks. This makes every window length, every clamp boundary, the zero-length escape and the full-cycle limits cheap to measure directly from `state_o`. Single-cycle sense pulses placed on the exact last cycle of a window exercise the priority of a sense over an expiry.

// File: rtl/pace_pkg.sv
`timescale 1ns/1ps
package pace_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REFR  = 3'd1,
    ST_ESC   = 3'd2,
    ST_BLANK = 3'd3,
    ST_XWIN  = 3'd4,
    ST_AVDLY = 3'd5,
    ST_SAFE  = 3'd6
  } pst_e;

  localparam int NUM_IV = 6;

  // interval register index that times a given state
  function automatic int iv_of(input pst_e s);
    case (s)
      ST_ESC:   return 1;
      ST_BLANK: return 2;
      ST_XWIN:  return 3;
      ST_AVDLY: return 4;
      ST_SAFE:  return 5;
      default:  return 0;
    endcase
  endfunction

  // limit a requested length to [lo, hi]
  function automatic int clamp_len(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pace_regs.sv
`timescale 1ns/1ps
module pace_regs #(
  parameter int W = 10,
  parameter int N = 6,
  parameter logic [N*W-1:0] LO_V  = '0,
  parameter logic [N*W-1:0] HI_V  = '1,
  parameter logic [N*W-1:0] DEF_V = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [2:0]     wr_sel_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [N*W-1:0] len_o
);
  import pace_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam int LO  = int'(LO_V[i*W +: W]);
    localparam int HI  = int'(HI_V[i*W +: W]);
    localparam int DEF = int'(DEF_V[i*W +: W]);
    localparam logic [W-1:0] RST = W'(clamp_len(DEF, LO, HI));
    logic [W-1:0] r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        r <= RST;
      else if (wr_en_i && (wr_sel_i == 3'(i)))
        r <= W'(clamp_len(int'(wr_data_i), LO, HI));
    end

    assign len_o[i*W +: W] = r;
  end

endmodule

// File: rtl/pace_timer.sv
`timescale 1ns/1ps
module pace_timer #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_len_i,
  output logic         exp_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt <= '0;
    else if (ld_i)
      cnt <= ld_len_i;
    else if (tick_i && (cnt != '0))
      cnt <= cnt - W'(1);
  end

  // expires on the tick that would bring the count to zero,
  // or at once when a zero length was loaded
  assign exp_o = (cnt == '0) || (tick_i && (cnt == W'(1)));

endmodule

// File: rtl/pace_fsm.sv
`timescale 1ns/1ps
module pace_fsm (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exp_i,
  input  logic               a_sense_i,
  input  logic               v_sense_i,
  output pace_pkg::pst_e     st_o,
  output pace_pkg::pst_e     nxt_o,
  output logic               go_o,
  output logic               a_pace_o,
  output logic               v_pace_o
);
  import pace_pkg::*;

  pst_e st, nxt;
  logic ap_d, vp_d;

  always_comb begin
    nxt  = st;
    ap_d = 1'b0;
    vp_d = 1'b0;
    case (st)
      ST_IDLE:  if (v_sense_i) nxt = ST_REFR;
      ST_REFR:  if (exp_i) nxt = ST_ESC;
      ST_ESC: begin
        if (v_sense_i)      nxt = ST_REFR;
        else if (a_sense_i) nxt = ST_BLANK;
        else if (exp_i) begin
          nxt  = ST_BLANK;
          ap_d = 1'b1;
        end
      end
      ST_BLANK: if (exp_i) nxt = ST_XWIN;
      ST_XWIN: begin
        if (v_sense_i)  nxt = ST_SAFE;
        else if (exp_i) nxt = ST_AVDLY;
      end
      ST_AVDLY: begin
        if (v_sense_i) nxt = ST_REFR;
        else if (exp_i) begin
          nxt  = ST_REFR;
          vp_d = 1'b1;
        end
      end
      ST_SAFE: begin
        if (exp_i) begin
          nxt  = ST_REFR;
          vp_d = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      a_pace_o <= 1'b0;
      v_pace_o <= 1'b0;
    end else begin
      st       <= nxt;
      a_pace_o <= ap_d;
      v_pace_o <= vp_d;
    end
  end

  assign st_o  = st;
  assign nxt_o = nxt;
  assign go_o  = (nxt != st);

endmodule

// File: rtl/pace_seq_top.sv
`timescale 1ns/1ps
module pace_seq_top #(
  parameter int W         = 10,
  parameter int REFR_LO   = 300,
  parameter int REFR_HI   = 400,
  parameter int REFR_DEF  = 350,
  parameter int ESC_LO    = 0,
  parameter int ESC_HI    = 400,
  parameter int ESC_DEF   = 300,
  parameter int BLANK_LO  = 25,
  parameter int BLANK_HI  = 25,
  parameter int BLANK_DEF = 25,
  parameter int XWIN_LO   = 75,
  parameter int XWIN_HI   = 75,
  parameter int XWIN_DEF  = 75,
  parameter int AVDLY_LO  = 100,
  parameter int AVDLY_HI  = 100,
  parameter int AVDLY_DEF = 100,
  parameter int SAFE_LO   = 50,
  parameter int SAFE_HI   = 110,
  parameter int SAFE_DEF  = 100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         a_sense_i,
  input  logic         v_sense_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [9:0]   wr_data_i,
  output logic         a_pace_o,
  output logic         v_pace_o,
  output logic [2:0]   state_o
);
  import pace_pkg::*;

  localparam int N = NUM_IV;
  localparam logic [N*W-1:0] LO_V  = {W'(SAFE_LO),  W'(AVDLY_LO),  W'(XWIN_LO),
                                      W'(BLANK_LO), W'(ESC_LO),    W'(REFR_LO)};
  localparam logic [N*W-1:0] HI_V  = {W'(SAFE_HI),  W'(AVDLY_HI),  W'(XWIN_HI),
                                      W'(BLANK_HI), W'(ESC_HI),    W'(REFR_HI)};
  localparam logic [N*W-1:0] DEF_V = {W'(SAFE_DEF), W'(AVDLY_DEF), W'(XWIN_DEF),
                                      W'(BLANK_DEF), W'(ESC_DEF),  W'(REFR_DEF)};

  // named internal events, observed by the bound checker
  logic [N*W-1:0] len_vec;
  logic [W-1:0]   ld_len;
  logic           tmr_exp;
  logic           tmr_ld;
  pst_e           cur_st;
  pst_e           nxt_st;

  pace_regs #(.W(W), .N(N), .LO_V(LO_V), .HI_V(HI_V), .DEF_V(DEF_V)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (W'(wr_data_i)),
    .len_o     (len_vec)
  );

  assign ld_len = len_vec[iv_of(nxt_st)*W +: W];

  pace_timer #(.W(W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ld_i     (tmr_ld),
    .ld_len_i (ld_len),
    .exp_o    (tmr_exp)
  );

  pace_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exp_i     (tmr_exp),
    .a_sense_i (a_sense_i),
    .v_sense_i (v_sense_i),
    .st_o      (cur_st),
    .nxt_o     (nxt_st),
    .go_o      (tmr_ld),
    .a_pace_o  (a_pace_o),
    .v_pace_o  (v_pace_o)
  );

  assign state_o = cur_st;

endmodule

// File: rtl/pace_chk.sv
`timescale 1ns/1ps
module pace_chk #(
  parameter int W = 10,
  parameter int N = 6,
  parameter logic [N*W-1:0] LO_V = '0,
  parameter logic [N*W-1:0] HI_V = '1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     state_i,
  input logic           a_pace_i,
  input logic           v_pace_i,
  input logic           exp_i,
  input logic           ld_i,
  input logic [W-1:0]   ld_len_i,
  input logic [N*W-1:0] len_i
);
  import pace_pkg::*;

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != 3'd7) else $error("illegal state code"); // R2

  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> (state_i == ST_IDLE || state_i == ST_REFR))
    else $error("idle left to wrong state"); // R1

  AST_ESC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ESC && $past(state_i) != ST_ESC) |-> $past(state_i) == ST_REFR)
    else $error("escape entered from wrong state"); // R4

  AST_PACE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_pace_i && v_pace_i)) else $error("both paces high"); // R5

  AST_APACE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_pace_i |-> (state_i == ST_BLANK && $past(state_i) == ST_ESC))
    else $error("atrial pace outside escape expiry"); // R5

  AST_VPACE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_pace_i |-> (state_i == ST_REFR &&
                  ($past(state_i) == ST_AVDLY || $past(state_i) == ST_SAFE)))
    else $error("ventricular pace outside delay expiry"); // R5

  AST_REFR_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_REFR && !exp_i) |=> state_i == ST_REFR)
    else $error("refractory left without expiry"); // R10

  AST_BLANK_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BLANK && !exp_i) |=> state_i == ST_BLANK)
    else $error("blanking left without expiry"); // R10

  AST_SAFE_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SAFE && !exp_i) |=> state_i == ST_SAFE)
    else $error("safety path left without expiry"); // R8

  AST_LOAD_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && ld_len_i > W'(1)) |=> !exp_i)
    else $error("timer expired right after a long load"); // R3

  for (genvar i = 0; i < N; i++) begin : g_rng
    localparam logic [W-1:0] LO = LO_V[i*W +: W];
    localparam logic [W-1:0] HI = HI_V[i*W +: W];
    logic [W-1:0] v;
    assign v = len_i[i*W +: W];
    // wrap-around distance from LO avoids a compare against zero
    AST_LEN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      W'(v - LO) <= W'(HI - LO)) else $error("interval register out of range"); // R12
  end

endmodule

bind pace_seq_top pace_chk #(.W(W), .N(N), .LO_V(LO_V), .HI_V(HI_V)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state_o),
  .a_pace_i (a_pace_o),
  .v_pace_i (v_pace_o),
  .exp_i    (tmr_exp),
  .ld_i     (tmr_ld),
  .ld_len_i (ld_len),
  .len_i    (len_vec)
);

// File: tb/sim_pace_seq_top.sv
`timescale 1ns/1ps
module sim_pace_seq_top;

  // state codes per R2
  localparam int S_IDLE = 0, S_REFR = 1, S_ESC = 2, S_BLANK = 3,
                 S_XWIN = 4, S_AVDLY = 5, S_SAFE = 6;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b1, as = 1'b0, vs = 1'b0, we = 1'b0;
  logic [2:0] ws = '0;
  logic [9:0] wd = '0;
  logic ap, vp;
  logic [2:0] st;

  int checks = 0, errors = 0, cyc = 0;

  pace_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .a_sense_i(as), .v_sense_i(vs),
    .wr_en_i(we), .wr_sel_i(ws), .wr_data_i(wd),
    .a_pace_o(ap), .v_pace_o(vp), .state_o(st)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; as = 1'b0; vs = 1'b0; we = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int d);
    ws = 3'(sel); wd = 10'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit v);
    as = a; vs = v;
    @(negedge clk);
    as = 1'b0; vs = 1'b0;
  endtask

  task automatic wait_st(input int k);
    int n = 0;
    while (int'(st) != k && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  int dur[8];
  int nap, nvp, tot, ap_ok, vp_end;

  // entered with st == refractory at a sample; runs until refractory returns
  task automatic run_cycle();
    bit left = 1'b0, done = 1'b0;
    int guard = 0;
    foreach (dur[i]) dur[i] = 0;
    nap = 0; nvp = 0; ap_ok = 1; vp_end = 0;
    dur[int'(st)]++;
    tot = 1;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (ap) begin nap++; if (int'(st) != S_BLANK) ap_ok = 0; end
      if (vp) nvp++;
      if (int'(st) != S_REFR) left = 1'b1;
      if (left && int'(st) == S_REFR) begin
        done = 1'b1;
        vp_end = int'(vp);
      end else begin
        dur[int'(st)]++;
        tot++;
      end
    end
  endtask

  localparam int NV = 9;
  localparam int TV_SEL[NV] = '{0, 0, 0, 1, 1, 1, 2, 3, 4};
  localparam int TV_DAT[NV] = '{250, 520, 333, 0, 999, 123, 3, 80, 700};
  localparam int TV_EXP[NV] = '{300, 400, 333, 0, 400, 123, 25, 75, 100};

  initial begin
    int n;
    // R1 reset state
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset state", int'(st), S_IDLE);
    chk("R1 reset a_pace", int'(ap), 0);
    chk("R1 reset v_pace", int'(vp), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    pulse(1, 0);
    chk("R1 atrial sense in idle ignored", int'(st), S_IDLE);
    pulse(0, 1);
    chk("R1 ventricular sense leaves idle", int'(st), S_REFR);
    chk("R1 no pace on idle exit", int'(ap) + int'(vp), 0);

    // R3 R4 R5 default cycle with reset lengths
    run_cycle();
    chk("R3 refractory default length", dur[S_REFR], 350);
    chk("R3 escape default length", dur[S_ESC], 300);
    chk("R4 blanking visited", dur[S_BLANK], 25);
    chk("R4 crosstalk visited", dur[S_XWIN], 75);
    chk("R4 AV delay visited", dur[S_AVDLY], 100);
    chk("R4 safety path not visited", dur[S_SAFE], 0);
    chk("R5 one atrial pace", nap, 1);
    chk("R5 atrial pace in first blanking cycle", ap_ok, 1);
    chk("R5 one ventricular pace", nvp, 1);
    chk("R5 ventricular pace at refractory entry", vp_end, 1);

    // R12 clamped register writes, table walk
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(TV_SEL[k], TV_DAT[k]);
      pulse(0, 1);
      run_cycle();
      chk($sformatf("R12 vector %0d length", k), dur[TV_SEL[k] + 1],
          (TV_EXP[k] == 0) ? 1 : TV_EXP[k]);
      chk($sformatf("R5 vector %0d atrial pace", k), nap * ap_ok, 1);
      chk($sformatf("R5 vector %0d ventricular pace", k), vp_end, 1);
    end

    // R3 tick low freezes the timer
    do_reset(); pulse(0, 1);
    tick = 1'b0;
    repeat (50) @(negedge clk);
    tick = 1'b1;
    n = 51;
    while (int'(st) == S_REFR && n < 3000) begin
      @(negedge clk);
      if (int'(st) == S_REFR) n++;
    end
    chk("R3 tick low holds timer", n, 400);

    // R10 senses in refractory change nothing
    do_reset(); pulse(0, 1);
    n = 1;
    while (int'(st) == S_REFR && n < 3000) begin
      as = (n == 5); vs = (n == 9) || (n == 200);
      @(negedge clk);
      if (int'(st) == S_REFR) n++;
    end
    as = 1'b0; vs = 1'b0;
    chk("R10 refractory length with senses", n, 350);
    wait_st(S_BLANK);
    pulse(1, 1);
    chk("R10 blanking ignores senses", int'(st), S_BLANK);

    // R6 escape window sensing
    do_reset(); pulse(0, 1); wait_st(S_ESC);
    pulse(0, 1);
    chk("R6 ventricular sense in escape", int'(st), S_REFR);
    chk("R6 no pace on ventricular sense", int'(ap) + int'(vp), 0);
    wait_st(S_ESC);
    pulse(1, 1);
    chk("R6 ventricular wins over atrial", int'(st), S_REFR);
    wait_st(S_ESC);
    pulse(1, 0);
    chk("R6 atrial sense to blanking", int'(st), S_BLANK);
    chk("R6 no atrial pace on sense", int'(ap), 0);

    // R11 sense on the last escape cycle beats expiry
    do_reset(); pulse(0, 1); wait_st(S_ESC);
    repeat (299) @(negedge clk);
    pulse(1, 0);
    chk("R11 atrial sense at escape expiry state", int'(st), S_BLANK);
    chk("R11 atrial sense at escape expiry no pace", int'(ap), 0);

    // R9 AV delay sensing, R11 on last AV cycle
    wait_st(S_AVDLY);
    pulse(1, 0);
    chk("R9 atrial sense in AV delay ignored", int'(st), S_AVDLY);
    pulse(0, 1);
    chk("R9 ventricular sense ends AV delay", int'(st), S_REFR);
    chk("R9 no pace on ventricular sense", int'(vp), 0);
    wait_st(S_AVDLY);
    repeat (99) @(negedge clk);
    pulse(0, 1);
    chk("R11 ventricular sense at AV expiry state", int'(st), S_REFR);
    chk("R11 ventricular sense at AV expiry no pace", int'(vp), 0);

    // R7 R8 safety path with default length
    do_reset(); pulse(0, 1); wait_st(S_XWIN);
    pulse(1, 0);
    chk("R7 atrial sense in crosstalk ignored", int'(st), S_XWIN);
    pulse(0, 1);
    chk("R7 ventricular sense to safety", int'(st), S_SAFE);
    n = 1;
    while (int'(st) == S_SAFE && n < 3000) begin
      as = (n == 3); vs = (n == 7);
      @(negedge clk);
      if (int'(st) == S_SAFE) n++;
    end
    as = 1'b0; vs = 1'b0;
    chk("R8 safety default length", n, 100);
    chk("R8 safety exit to refractory", int'(st), S_REFR);
    chk("R8 safety exit paces ventricle", int'(vp), 1);

    // R8 R12 safety length clamped up to 50
    do_reset(); wr(5, 20); pulse(0, 1); wait_st(S_XWIN);
    pulse(0, 1);
    n = 1;
    while (int'(st) == S_SAFE && n < 3000) begin
      @(negedge clk);
      if (int'(st) == S_SAFE) n++;
    end
    chk("R12 safety clamp to lower limit", n, 50);
    chk("R8 safety clamp exit pace", int'(vp), 1);

    // R13 whole-cycle limits
    do_reset(); wr(0, 400); wr(1, 400); pulse(0, 1);
    run_cycle();
    chk("R13 cycle at upper limits", tot, 1000);
    do_reset(); wr(0, 300); wr(1, 0); pulse(0, 1);
    run_cycle();
    chk("R13 cycle at lower limits", tot, 501);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule